// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block steps a processor core between four operating modes: full operation with caches on, operation with caches off, sleep and stop. Software selects a mode by writing a two-bit request with a write strobe. The block turns the current mode into three control outputs: a core clock gate, a PLL enable and a cache enable. It also produces a clock enable for the internal bus interface, which runs at half the core clock rate.

The two low-power modes have different exit paths. In sleep the core clock is gated but the PLL keeps running, so a pulse on an external wake pin returns the core to full operation within a few cycles. In stop the PLL is also switched off. The wake pin has no effect there, and only a reset brings the core back. After any reset the block holds the core clock gated in a lock-wait phase until the PLL reports lock. A status port shows the current mode and whether the block is waiting for lock.

Top module: `pwr_mode_seq`

## Requirements
- R1: During and after reset the block is in lock wait. `lock_wait`=1, `core_clk_en`=0, `pll_en`=1, `cache_en`=0 and `mode_stat`=2'b00. It stays there while `pll_lock` is low. After the first clock edge that samples `pll_lock` high, it is in normal mode.
- R2: In normal mode `core_clk_en`=1, `pll_en`=1, `cache_en`=1, `lock_wait`=0 and `mode_stat`=2'b00.
- R3: Request codes on `req_mode` are 2'b00 normal, 2'b01 cache-off, 2'b10 sleep and 2'b11 stop. A write accepted in normal or cache-off mode changes the mode at the clock edge that samples `req_we` high. The new mode shows on the outputs in the cycle after the strobe.
- R4: In cache-off mode `core_clk_en`=1, `pll_en`=1, `cache_en`=0 and `mode_stat`=2'b01. A write of 2'b00 returns the block to normal mode.
- R5: In sleep mode `core_clk_en`=0, `pll_en`=1, `cache_en`=0 and `mode_stat`=2'b10.
- R6: `wake_pin` passes through a two-stage synchronizer. A pin pulse one cycle wide, driven before clock edge e1, leaves the block still in sleep after edge e2 and in normal mode after edge e3.
- R7: In stop mode `core_clk_en`=0, `pll_en`=0, `cache_en`=0 and `mode_stat`=2'b11. Wake pin pulses and writes leave it in stop.
- R8: Asserting `rst_n` low while in stop puts the block in lock wait. Normal mode follows once `pll_lock` is high.
- R9: Writes are ignored in sleep, stop and lock wait. If a wake pulse and a write reach the block in the same sleep cycle, the wake takes effect and the write is discarded. It is not applied later.
- R10: `bus_clk_en` is 0 whenever `core_clk_en` is 0. When the core clock restarts, `bus_clk_en` is 0 in the first running cycle and 1 in the second, then alternates every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | 1 | Mode request write strobe |
| req_mode | input | 2 | Requested mode code |
| wake_pin | input | 1 | External wake pin, asynchronous |
| pll_lock | input | 1 | PLL lock indication |
| core_clk_en | output | 1 | Core clock gate enable |
| pll_en | output | 1 | PLL enable |
| cache_en | output | 1 | Cache enable |
| bus_clk_en | output | 1 | Half-rate bus interface clock enable |
| lock_wait | output | 1 | High while waiting for PLL lock |
| mode_stat | output | 2 | Current mode code |

## Verification
The two functions that can fall in the same cycle are the synchronized wake event and a software mode write, both arriving while the core sleeps. The bench pulses the wake pin and times a stop request so that its strobe is sampled at the same edge where the synchronized wake reaches the sequencer. It then checks that the block lands in normal mode and stays there on the following cycle, which shows the write was neither taken nor deferred. A second overlap is the restart of the bus-clock divider on the same edge that ungates the core clock. This is judged by the 0,1,0,1 pattern on `bus_clk_en` after every wake and every lock.

// File: rtl/pms_pkg.sv
package pms_pkg;

   localparam int unsigned MODE_W = 2;

   localparam logic [MODE_W-1:0] CODE_NORMAL = 2'b00;
   localparam logic [MODE_W-1:0] CODE_NOCACHE = 2'b01;
   localparam logic [MODE_W-1:0] CODE_SLEEP = 2'b10;
   localparam logic [MODE_W-1:0] CODE_STOP = 2'b11;

   typedef enum logic [2:0] {
      PM_LOCKWAIT = 3'd0,
      PM_NORMAL   = 3'd1,
      PM_NOCACHE  = 3'd2,
      PM_SLEEP    = 3'd3,
      PM_STOP     = 3'd4
   } pm_state_e;

   function automatic pm_state_e code_to_state(input logic [MODE_W-1:0] code);
      pm_state_e s;
      case (code)
         CODE_NORMAL:  s = PM_NORMAL;
         CODE_NOCACHE: s = PM_NOCACHE;
         CODE_SLEEP:   s = PM_SLEEP;
         default:      s = PM_STOP;
      endcase
      return s;
   endfunction

   function automatic logic [MODE_W-1:0] state_to_code(input pm_state_e s);
      logic [MODE_W-1:0] c;
      case (s)
         PM_NOCACHE: c = CODE_NOCACHE;
         PM_SLEEP:   c = CODE_SLEEP;
         PM_STOP:    c = CODE_STOP;
         default:    c = CODE_NORMAL;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pms_wake_sync.sv
module pms_wake_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pms_wake_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_async};
      end
   end

   assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pms_bus_div.sv
module pms_bus_div #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   if (DIV < 1) begin : g_bad_div
      $error("pms_bus_div: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick = run;
   end else begin : g_count
      localparam int unsigned PH_W = $clog2(DIV);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

      logic [PH_W-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase_q <= '0;
         end else if (!run) begin
            phase_q <= '0;
         end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end

      assign tick = run && (phase_q == PH_LAST);

      // R10
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);

      // R10
      first_run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> !tick);
   end

endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
   import pms_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_we,
   input  logic [MODE_W-1:0] req_mode,
   input  logic              wake_s,
   input  logic              pll_lock,
   output pm_state_e         state
);

   pm_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         PM_LOCKWAIT: if (pll_lock) st_d = PM_NORMAL;
         PM_NORMAL, PM_NOCACHE: if (req_we) st_d = code_to_state(req_mode);
         PM_SLEEP: if (wake_s) st_d = PM_NORMAL;
         PM_STOP: st_d = PM_STOP;
         default: st_d = PM_LOCKWAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= PM_LOCKWAIT;
      end else begin
         st_q <= st_d;
      end
   end

   assign state = st_q;

   // R1
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_LOCKWAIT) && !pll_lock |=> st_q == PM_LOCKWAIT);

   // R3
   write_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == PM_NORMAL) || (st_q == PM_NOCACHE)) && req_we
      |=> st_q == code_to_state($past(req_mode)));

   // R6
   wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_SLEEP) && wake_s |=> st_q == PM_NORMAL);

   // R7
   stop_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == PM_STOP |=> st_q == PM_STOP);

   // R9
   sleep_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_SLEEP) && !wake_s |=> st_q == PM_SLEEP);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BUS_DIV     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_we,
   input  logic [1:0] req_mode,
   input  logic       wake_pin,
   input  logic       pll_lock,
   output logic       core_clk_en,
   output logic       pll_en,
   output logic       cache_en,
   output logic       bus_clk_en,
   output logic       lock_wait,
   output logic [1:0] mode_stat
);
   import pms_pkg::*;

   logic      wake_s;
   pm_state_e cur;

   pms_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (wake_pin),
      .pin_sync  (wake_s)
   );

   pms_mode_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_we   (req_we),
      .req_mode (req_mode),
      .wake_s   (wake_s),
      .pll_lock (pll_lock),
      .state    (cur)
   );

   assign core_clk_en = (cur == PM_NORMAL) || (cur == PM_NOCACHE);
   assign pll_en      = (cur != PM_STOP);
   assign cache_en    = (cur == PM_NORMAL);
   assign lock_wait   = (cur == PM_LOCKWAIT);
   assign mode_stat   = state_to_code(cur);

   pms_bus_div #(.DIV(BUS_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (core_clk_en),
      .tick  (bus_clk_en)
   );

   // R7
   clk_needs_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en |-> pll_en);

   // R4
   cache_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_en |-> core_clk_en);

   // R10
   bus_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |-> !bus_clk_en);

endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;

   localparam int CLK_P = 10;
   localparam int WDOG_CYC = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_we = 1'b0;
   logic [1:0] req_mode = 2'b00;
   logic       wake_pin = 1'b0;
   logic       pll_lock = 1'b0;
   logic       core_clk_en, pll_en, cache_en, bus_clk_en, lock_wait;
   logic [1:0] mode_stat;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // outputs packed as {lock_wait, core_clk_en, pll_en, cache_en, mode_stat}
   localparam logic [5:0] V_LOCK  = 6'b101000;
   localparam logic [5:0] V_NORM  = 6'b011100;
   localparam logic [5:0] V_NOC   = 6'b011001;
   localparam logic [5:0] V_SLEEP = 6'b001010;
   localparam logic [5:0] V_STOP  = 6'b000011;

   always #(CLK_P/2) clk = ~clk;

   pwr_mode_seq u_pwr_mode_seq (
      .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_mode(req_mode),
      .wake_pin(wake_pin), .pll_lock(pll_lock), .core_clk_en(core_clk_en),
      .pll_en(pll_en), .cache_en(cache_en), .bus_clk_en(bus_clk_en),
      .lock_wait(lock_wait), .mode_stat(mode_stat)
   );

   function automatic logic [5:0] outs();
      return {lock_wait, core_clk_en, pll_en, cache_en, mode_stat};
   endfunction

   task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_mode(input logic [1:0] m);
      req_we = 1'b1;
      req_mode = m;
      @(negedge clk);
      req_we = 1'b0;
   endtask

   task automatic bus_pattern(input string tag);
      // called at the first running cycle
      chk({tag, " bus c1"}, {5'd0, bus_clk_en}, 6'd0);
      cyc(1);
      chk({tag, " bus c2"}, {5'd0, bus_clk_en}, 6'd1);
      cyc(1);
      chk({tag, " bus c3"}, {5'd0, bus_clk_en}, 6'd0);
      cyc(1);
      chk({tag, " bus c4"}, {5'd0, bus_clk_en}, 6'd1);
   endtask

   task automatic t_reset_lock();
      rst_n = 1'b0;
      pll_lock = 1'b0;
      cyc(2);
      chk("R1 in reset", outs(), V_LOCK);
      rst_n = 1'b1;
      cyc(4);
      chk("R1 lock wait holds", outs(), V_LOCK);
      chk("R10 gated bus", {5'd0, bus_clk_en}, 6'd0);
      pll_lock = 1'b1;
      cyc(1);
      chk("R1 R2 normal after lock", outs(), V_NORM);
      bus_pattern("R10 after lock");
   endtask

   task automatic t_nocache();
      write_mode(2'b01);
      chk("R3 R4 cache-off", outs(), V_NOC);
      cyc(3);
      chk("R4 cache-off holds", outs(), V_NOC);
      write_mode(2'b00);
      chk("R4 back to normal", outs(), V_NORM);
   endtask

   task automatic t_sleep_wake();
      write_mode(2'b10);
      chk("R5 sleep", outs(), V_SLEEP);
      write_mode(2'b01);
      chk("R9 write ignored in sleep", outs(), V_SLEEP);
      wake_pin = 1'b1;
      @(negedge clk);
      wake_pin = 1'b0;
      chk("R6 after e1", outs(), V_SLEEP);
      cyc(1);
      chk("R6 after e2", outs(), V_SLEEP);
      cyc(1);
      chk("R6 wake to normal", outs(), V_NORM);
      bus_pattern("R10 after wake");
   endtask

   task automatic t_wake_write_collide();
      write_mode(2'b10);
      chk("R5 sleep again", outs(), V_SLEEP);
      wake_pin = 1'b1;
      cyc(1);
      wake_pin = 1'b0;
      cyc(1);
      req_we = 1'b1;
      req_mode = 2'b11;
      cyc(1);
      req_we = 1'b0;
      chk("R9 wake wins", outs(), V_NORM);
      cyc(1);
      chk("R9 write not deferred", outs(), V_NORM);
   endtask

   task automatic t_stop();
      write_mode(2'b11);
      chk("R7 stop", outs(), V_STOP);
      wake_pin = 1'b1;
      cyc(1);
      wake_pin = 1'b0;
      cyc(5);
      chk("R7 wake ignored", outs(), V_STOP);
      write_mode(2'b00);
      cyc(1);
      chk("R7 write ignored", outs(), V_STOP);
      chk("R10 bus off in stop", {5'd0, bus_clk_en}, 6'd0);
      pll_lock = 1'b0;
      rst_n = 1'b0;
      cyc(1);
      rst_n = 1'b1;
      cyc(2);
      chk("R8 reset exits stop", outs(), V_LOCK);
      pll_lock = 1'b1;
      cyc(1);
      chk("R8 normal after lock", outs(), V_NORM);
   endtask

   initial begin
      cyc(1);
      t_reset_lock();
      t_nocache();
      t_sleep_wake();
      t_wake_write_collide();
      t_stop();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < WDOG_CYC; i++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule